// File: doc/BRIEF.md
# SDRAM Burst Engine with Clock Suspend

This block is a cycle-level model of one bank of a synchronous DRAM, covering the data path and the command timing. On every rising clock edge it samples a command word (no-op, open row, read, write, close row) and a column address. It runs fixed-length read and write bursts against a small internal array, with a configurable burst length and read latency. A bank is opened with the open-row command. Reads and writes are accepted only while the bank is open. The close-row command shuts the bank.

The clock-enable input can freeze the block in the middle of a burst. If clock enable is sampled low while the bank is open, the edge that samples it still executes normally. From the following edge on, every internal sequencer stands still. While frozen, commands are ignored, read data stays driven on the output, and write data on the input is discarded. When clock enable is sampled high again, that edge is still frozen, and normal operation resumes on the edge after it. A status output shows whether the block is frozen. A low clock enable while the bank is closed has no effect.

Top module: `sdr_burst_engine`

## Requirements
- R1: After reset, dq_oe is 0, dq_out is 0, bank_open is 0, suspended is 0, and every array word reads as zero.
- R2: Commands are coded as 0 = no-op, 1 = open row, 2 = read, 3 = write, 4 = close row. Open row sets bank_open after the sampling edge and close row clears it. Read and write commands sampled while bank_open is 0 are ignored: no data is driven and no array word changes.
- R3: With read latency CL = 2 and burst length 4, read word 0 is on dq_out with dq_oe at 1 after the CL-th rising edge following the edge that samples the read command. Words 1 to 3 follow on the next three edges, and dq_oe returns to 0 on the edge after that.
- R4: Burst columns start at the given column and increment in the two low address bits, wrapping inside the aligned block of 4. For example, a start at 6 gives 6, 7, 4, 5.
- R5: The edge that samples a write command stores dq_in at the start column. The next three edges store dq_in at the following columns of the burst order. Later edges store nothing.
- R6: If clock enable is sampled low on an edge while bank_open is 1, that edge still executes normally, including any command on it, and suspended reads 1 after it.
- R7: If clock enable is sampled high on an edge while suspended is 1, that edge is still frozen and suspended reads 0 after it. The next edge runs normally.
- R8: A command sampled on a frozen edge is ignored. For example, a close row sent during suspend leaves bank_open at 1.
- R9: While suspended, dq_out and dq_oe keep the value driven before the freeze. After exit, the read burst continues with its next word and still delivers exactly 4 words.
- R10: dq_in sampled on frozen edges is not written. After exit, the write burst stores the remaining words at the next columns of its order.
- R11: A low clock enable sampled while bank_open is 0 does not set suspended, and commands on those edges execute normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; sampled low while the bank is open, it freezes the block one edge later |
| cmd | input | 3 | Command code (0 no-op, 1 open row, 2 read, 3 write, 4 close row) |
| addr | input | COL_W (4) | Burst start column |
| dq_in | input | DATA_W (8) | Write data |
| dq_out | output | DATA_W (8) | Read data |
| dq_oe | output | 1 | High while dq_out carries a read word |
| bank_open | output | 1 | The bank is open |
| suspended | output | 1 | Clock suspend is in effect |

## Verification
Write-then-read bursts are run from start columns at the base, in the middle and at the top of an aligned block. Because each burst uses distinct data, a wrong wrap point or a wrong starting word shows up as a mismatch in a specific slot. Three suspend patterns are tried. The first drops clock enable in the middle of a read, which separates holding the data on the bus from advancing or blanking it. The second drops clock enable on the very edge of a read command, which shows whether the command is accepted and whether the latency pipeline is frozen. The third freezes a write while junk data is on the input, so a masked word and a late column both become visible on the read-back. Clock enable is also held low with the bank closed, to show that no suspend occurs, and reads and writes are sent to a closed bank to show that they leave no trace.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_ACTIVE    = 3'd1,
        CMD_READ      = 3'd2,
        CMD_WRITE     = 3'd3,
        CMD_PRECHARGE = 3'd4
    } sdr_cmd_e;

    typedef struct packed {
        logic open_row;
        logic rd;
        logic wr;
        logic close_row;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [2:0] code);
        cmd_dec_t d;
        d.open_row  = (code == CMD_ACTIVE);
        d.rd        = (code == CMD_READ);
        d.wr        = (code == CMD_WRITE);
        d.close_row = (code == CMD_PRECHARGE);
        return d;
    endfunction

endpackage

// File: rtl/sdr_cke_ctrl.sv
module sdr_cke_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic bank_open,
    output logic suspended,
    output logic run
);
    logic susp_q;

    // The freeze starts one edge after the low sample, and it ends one edge after the high sample.
    always_ff @(posedge clk) begin
        if (rst) susp_q <= 1'b0;
        else     susp_q <= ~cke & bank_open;
    end

    assign suspended = susp_q;
    assign run       = ~susp_q;
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq #(
    parameter int COL_W = 4,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic             abort,
    input  logic [COL_W-1:0] start_col,
    output logic             act,
    output logic [COL_W-1:0] col
);
    localparam int BL_W  = $clog2(BURST);
    localparam int CNT_W = $clog2(BURST + 1);

    logic [CNT_W-1:0] left_q;
    logic [COL_W-1:0] col_q;
    logic             busy;

    function automatic logic [COL_W-1:0] wrap_inc(input logic [COL_W-1:0] c);
        logic [COL_W-1:0] r;
        r = c;
        r[BL_W-1:0] = c[BL_W-1:0] + 1'b1;
        return r;
    endfunction

    assign busy = (left_q != '0);
    assign col  = start ? start_col : col_q;
    assign act  = run & (start | (busy & ~abort));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            col_q  <= '0;
        end else if (run) begin
            if (start) begin
                left_q <= CNT_W'(BURST - 1);
                col_q  <= wrap_inc(start_col);
            end else if (abort) begin
                left_q <= '0;
            end else if (busy) begin
                left_q <= left_q - 1'b1;
                col_q  <= wrap_inc(col_q);
            end
        end
    end
endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe #(
    parameter int COL_W = 4,
    parameter int CL    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             in_valid,
    input  logic [COL_W-1:0] in_col,
    output logic             out_valid,
    output logic [COL_W-1:0] out_col
);
    typedef struct packed {
        logic             valid;
        logic [COL_W-1:0] col;
    } stage_t;

    stage_t st [CL];

    always_ff @(posedge clk) begin
        if (rst)      st[0] <= '0;
        else if (run) st[0] <= '{valid: in_valid, col: in_col};
    end

    for (genvar i = 1; i < CL; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)      st[i] <= '0;
            else if (run) st[i] <= st[i-1];
        end
    end

    assign out_valid = st[CL-1].valid;
    assign out_col   = st[CL-1].col;
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
    import sdr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COL_W  = 4,
    parameter int BURST  = 4,
    parameter int CL     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic [2:0]        cmd,
    input  logic [COL_W-1:0]  addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              bank_open,
    output logic              suspended
);
    localparam int DEPTH = 1 << COL_W;

    logic              run;
    logic              bank_q;
    cmd_dec_t          dec;
    logic              go_open, go_close, go_rd, go_wr;
    logic              rd_act, wr_act, pipe_valid;
    logic [COL_W-1:0]  rd_col, wr_col, pipe_col;
    logic [DATA_W-1:0] mem [DEPTH];

    assign dec      = decode_cmd(cmd);
    assign go_open  = run & dec.open_row;
    assign go_close = run & dec.close_row;
    assign go_rd    = run & bank_q & dec.rd;
    assign go_wr    = run & bank_q & dec.wr;

    sdr_cke_ctrl u_cke (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .bank_open (bank_q),
        .suspended (suspended),
        .run       (run)
    );

    sdr_burst_seq #(.COL_W(COL_W), .BURST(BURST)) u_rd_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .start     (go_rd),
        .abort     (go_wr),
        .start_col (addr),
        .act       (rd_act),
        .col       (rd_col)
    );

    sdr_burst_seq #(.COL_W(COL_W), .BURST(BURST)) u_wr_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .start     (go_wr),
        .abort     (go_rd),
        .start_col (addr),
        .act       (wr_act),
        .col       (wr_col)
    );

    sdr_read_pipe #(.COL_W(COL_W), .CL(CL)) u_rd_pipe (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .in_valid  (rd_act),
        .in_col    (rd_col),
        .out_valid (pipe_valid),
        .out_col   (pipe_col)
    );

    always_ff @(posedge clk) begin
        if (rst)           bank_q <= 1'b0;
        else if (go_open)  bank_q <= 1'b1;
        else if (go_close) bank_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_act) begin
            mem[wr_col] <= dq_in;
        end
    end

    // Output register: it holds its value on frozen edges, so the last word stays on the bus.
    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else if (run) begin
            dq_oe  <= pipe_valid;
            dq_out <= pipe_valid ? mem[pipe_col] : '0;
        end
    end

    assign bank_open = bank_q;
endmodule

// File: rtl/sdr_burst_engine_chk.sv
module sdr_burst_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              bank_open,
    input logic              suspended,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);
    // R6: a low clock enable with the bank open puts the block in suspend on the next edge
    a_r6_enter_suspend: assert property (@(posedge clk) disable iff (rst)
        (!cke && bank_open) |=> suspended);

    // R7: a high clock enable always clears suspend on the next edge
    a_r7_leave_suspend: assert property (@(posedge clk) disable iff (rst)
        cke |=> !suspended);

    // R8: a frozen edge cannot change the bank state
    a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
        suspended |=> $stable(bank_open));

    // R9: the read bus is held across a frozen edge
    a_r9_bus_held: assert property (@(posedge clk) disable iff (rst)
        suspended |=> ($stable(dq_out) && $stable(dq_oe)));

    // R11: with the bank closed, no suspend can begin
    a_r11_no_idle_suspend: assert property (@(posedge clk) disable iff (rst)
        (!bank_open && !suspended) |=> !suspended);
endmodule

bind sdr_burst_engine sdr_burst_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .bank_open (bank_open),
    .suspended (suspended),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/sdr_burst_engine_tb.sv
`timescale 1ns/1ps
module sdr_burst_engine_tb;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int DEPTH = 1 << CW;

    localparam logic [2:0] C_NOP = 3'd0, C_OPEN = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_CLOSE = 3'd4;

    typedef struct packed {
        logic [CW-1:0] col;
        logic [DW-1:0] seed;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{col: 4'd0,  seed: 8'h10},
        '{col: 4'd5,  seed: 8'h20},
        '{col: 4'd10, seed: 8'h30},
        '{col: 4'd15, seed: 8'h40}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b1;
    logic [2:0]    cmd = 3'd0;
    logic [CW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, bank_open, suspended;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] shadow [DEPTH];

    always #2 clk = ~clk;

    sdr_burst_engine u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .bank_open(bank_open), .suspended(suspended)
    );

    function automatic logic [CW-1:0] nxt(input logic [CW-1:0] c);
        return {c[CW-1:2], c[1:0] + 2'd1};
    endfunction

    task automatic step(input logic [2:0] c, input logic [CW-1:0] a,
                        input logic [DW-1:0] d, input logic k);
        cmd = c; addr = a; dq_in = d; cke = k;
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_burst(input logic [CW-1:0] col, input logic [DW-1:0] base);
        logic [CW-1:0] c;
        c = col;
        step(C_WR, col, base, 1'b1);
        shadow[c] = base;
        for (int i = 1; i < 4; i++) begin
            c = nxt(c);
            step(C_NOP, '0, base + DW'(i), 1'b1);
            shadow[c] = base + DW'(i);
        end
        step(C_NOP, '0, 8'hEE, 1'b1);
    endtask

    task automatic rd_burst(input logic [CW-1:0] col, input string tag);
        logic [CW-1:0] c;
        c = col;
        step(C_RD, col, '0, 1'b1);
        step(C_NOP, '0, '0, 1'b1);
        step(C_NOP, '0, '0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            chk({tag, " oe"}, 32'(dq_oe), 32'd1);
            chk({tag, " data"}, 32'(dq_out), 32'(shadow[c]));
            c = nxt(c);
            step(C_NOP, '0, '0, 1'b1);
        end
        chk({tag, " oe end"}, 32'(dq_oe), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 dq_oe", 32'(dq_oe), 32'd0);
        chk("R1 dq_out", 32'(dq_out), 32'd0);
        chk("R1 bank_open", 32'(bank_open), 32'd0);
        chk("R1 suspended", 32'(suspended), 32'd0);

        // R2 read and write to a closed bank are ignored
        step(C_RD, 4'd3, '0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(C_NOP, '0, '0, 1'b1);
            chk("R2 closed read oe", 32'(dq_oe), 32'd0);
        end
        step(C_WR, 4'd0, 8'h5A, 1'b1);
        for (int i = 0; i < 3; i++) step(C_NOP, '0, 8'h5B, 1'b1);
        step(C_OPEN, '0, '0, 1'b1);
        chk("R2 open", 32'(bank_open), 32'd1);
        rd_burst(4'd0, "R1 R2 closed write left zeros");

        // R3 R4 R5 table of write then read bursts
        for (int v = 0; v < 4; v++) begin
            wr_burst(VECS[v].col, VECS[v].seed);
            rd_burst(VECS[v].col, "R3 R4 R5 table");
        end
        rd_burst(4'd2, "R4 wrap from 2");

        // R6 R7 R8 R9 suspend in the middle of a read from column 0
        step(C_RD, 4'd0, '0, 1'b1);
        step(C_NOP, '0, '0, 1'b1);
        step(C_NOP, '0, '0, 1'b1);
        chk("R9 word0", 32'(dq_out), 32'(shadow[0]));
        step(C_NOP, '0, '0, 1'b0);
        chk("R6 entry edge runs", 32'(dq_out), 32'(shadow[1]));
        chk("R6 suspended", 32'(suspended), 32'd1);
        step(C_NOP, '0, '0, 1'b0);
        chk("R9 held", 32'(dq_out), 32'(shadow[1]));
        chk("R9 oe held", 32'(dq_oe), 32'd1);
        step(C_CLOSE, '0, '0, 1'b0);
        chk("R8 close ignored", 32'(bank_open), 32'd1);
        chk("R9 held2", 32'(dq_out), 32'(shadow[1]));
        step(C_NOP, '0, '0, 1'b1);
        chk("R7 exit", 32'(suspended), 32'd0);
        chk("R7 exit edge frozen", 32'(dq_out), 32'(shadow[1]));
        step(C_NOP, '0, '0, 1'b1);
        chk("R9 resume word2", 32'(dq_out), 32'(shadow[2]));
        step(C_NOP, '0, '0, 1'b1);
        chk("R9 word3", 32'(dq_out), 32'(shadow[3]));
        step(C_NOP, '0, '0, 1'b1);
        chk("R9 four words only", 32'(dq_oe), 32'd0);

        // R6 read command on the edge that samples clock enable low
        step(C_RD, 4'd4, '0, 1'b0);
        chk("R6 cmd edge suspended", 32'(suspended), 32'd1);
        step(C_NOP, '0, '0, 1'b0);
        chk("R6 frozen oe", 32'(dq_oe), 32'd0);
        step(C_NOP, '0, '0, 1'b1);
        chk("R7 exit2", 32'(suspended), 32'd0);
        chk("R7 frozen oe", 32'(dq_oe), 32'd0);
        step(C_NOP, '0, '0, 1'b1);
        chk("R9 latency stretched", 32'(dq_oe), 32'd0);
        for (int i = 4; i < 8; i++) begin
            step(C_NOP, '0, '0, 1'b1);
            chk("R6 accepted read data", 32'(dq_out), 32'(shadow[i]));
        end
        step(C_NOP, '0, '0, 1'b1);
        chk("R6 end oe", 32'(dq_oe), 32'd0);

        // R10 write masked while suspended
        step(C_WR, 4'd8, 8'hA0, 1'b1);
        step(C_NOP, '0, 8'hA1, 1'b1);
        step(C_NOP, '0, 8'hA2, 1'b0);
        chk("R10 suspended", 32'(suspended), 32'd1);
        step(C_NOP, '0, 8'hBD, 1'b0);
        step(C_NOP, '0, 8'hBE, 1'b1);
        chk("R10 exit", 32'(suspended), 32'd0);
        step(C_NOP, '0, 8'hA3, 1'b1);
        step(C_NOP, '0, 8'hBF, 1'b1);
        shadow[8] = 8'hA0; shadow[9] = 8'hA1; shadow[10] = 8'hA2; shadow[11] = 8'hA3;
        rd_burst(4'd8, "R10 masked write");

        // R2 close row
        step(C_CLOSE, '0, '0, 1'b1);
        chk("R2 close", 32'(bank_open), 32'd0);

        // R11 low clock enable with the bank closed
        for (int i = 0; i < 3; i++) begin
            step(C_NOP, '0, '0, 1'b0);
            chk("R11 no suspend", 32'(suspended), 32'd0);
        end
        step(C_OPEN, '0, '0, 1'b0);
        chk("R11 open accepted", 32'(bank_open), 32'd1);
        chk("R11 still running", 32'(suspended), 32'd0);
        step(C_NOP, '0, '0, 1'b0);
        chk("R6 suspend after open", 32'(suspended), 32'd1);
        step(C_NOP, '0, '0, 1'b1);
        chk("R7 exit3", 32'(suspended), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule